// File: doc/BRIEF.md
# Change-of-State Interrupt Detector

This block watches a vector of already-synchronized input lines, organised as banks of equal width, and records every qualifying transition as a sticky status bit. In the default build there are four 8-bit banks. Banks 0 to 2 carry the 24 isolated inputs and bank 3 carries the 8 lines of the bidirectional port. Each bank has one rising-edge enable and one falling-edge enable. One enable byte holds them: the rising enables sit in the low half and the falling enables in the high half.

Software reads all status bits as one word, with bank 0 in the least significant byte. It clears bits by writing ones through per-bank byte-lane strobes. A single level interrupt output stays asserted while any status bit is set, so an all-zero status word means the block is not requesting service. Input synchronization and the bus address decode sit outside this block.

Top module: `cos_detector`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cos_status` is all zeros and `irq` is 0.
- R2: When enable bit n (n < NUM_BANKS) is 1 and a line of bank n goes from 0 to 1, status bit n*BANK_W+i becomes 1 after the clock edge that samples the new level.
- R3: When enable bit n+NUM_BANKS is 1 and a line of bank n goes from 1 to 0, the corresponding status bit becomes 1 after the clock edge that samples the new level.
- R4: An edge whose direction is not enabled for its bank sets no status bit.
- R5: A status bit that is set stays set until it is cleared.
- R6: A status bit i of bank b is cleared when `clr_lane[b]` is 1 and `clr_data[i]` is 1. Bits whose lane strobe is 0, or whose data bit is 0, are unaffected. Setting all lanes with all-ones data clears the whole word in one cycle.
- R7: When an enabled edge on a line and a clear of its status bit arrive in the same cycle, the status bit ends up set.
- R8: `irq` is 1 exactly when at least one status bit is 1. It is combinational from the status register in the default build.
- R9: Leaving reset produces no status bits. The reference copy of the inputs is loaded from the live inputs in the first cycle after reset, and edges are compared only from the second cycle on.
- R10: Clearing a bank's enables stops new status bits from being set, but does not clear status bits that are already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | NUM_BANKS*BANK_W | Synchronized input lines, bank 0 in the low bits |
| edge_en | input | 2*NUM_BANKS | Rising enables in the low half, falling enables in the high half, one per bank |
| clr_lane | input | NUM_BANKS | Byte-lane clear strobes, one per bank |
| clr_data | input | NUM_BANKS*BANK_W | Write-one-to-clear data |
| cos_status | output | NUM_BANKS*BANK_W | Sticky change-of-state status word |
| irq | output | 1 | Level interrupt request, the OR of all status bits |

## Verification
The bench builds the block with its defaults: four banks of eight lines and a combinational interrupt output. This gives the full 32-bit status word, every lane strobe and all eight enable bits. Directed steps cover each corner case. These are edges on bank boundaries, edges arriving while their direction is disabled, a set and a clear landing on the same bit in one cycle, and partial-lane clears. A long run of random inputs, enables and clears then hits mixed set-and-clear patterns across all banks at once.

// File: rtl/cosd_pkg.sv
package cosd_pkg;
   // Selects how the interrupt output is produced from the status word
   typedef enum bit {
      IRQ_COMB = 1'b0,
      IRQ_REG  = 1'b1
   } irq_style_e;
endpackage

// File: rtl/cosd_bank.sv
module cosd_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         primed,
   input  logic         rise_en,
   input  logic         fall_en,
   input  logic [W-1:0] din,
   input  logic [W-1:0] clr_mask,
   output logic [W-1:0] status,
   output logic [W-1:0] hit_o
);
   logic [W-1:0] prev_q;
   logic [W-1:0] stat_q;
   logic [W-1:0] rise;
   logic [W-1:0] fall;
   logic [W-1:0] hit;

   always_comb begin
      rise = din & ~prev_q;
      fall = ~din & prev_q;
      if (primed)
         hit = (rise & {W{rise_en}}) | (fall & {W{fall_en}});
      else
         hit = '0;
   end

   // reference copy follows the inputs every cycle, so the first
   // post-reset cycle loads it without reporting edges
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         stat_q <= '0;
      end else begin
         prev_q <= din;
         stat_q <= (stat_q & ~clr_mask) | hit;
      end
   end

   assign status = stat_q;
   assign hit_o  = hit;

   // R6
   clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & $past(clr_mask & ~hit)) == '0));

   // R5
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & $past(stat_q & ~clr_mask)) == $past(stat_q & ~clr_mask)));

   // R4
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(hit)) == '0));

   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & $past(hit)) == $past(hit)));
endmodule

// File: rtl/cosd_irq_out.sv
module cosd_irq_out
   import cosd_pkg::*;
#(
   parameter int         W     = 32,
   parameter irq_style_e STYLE = IRQ_COMB
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] status,
   output logic         irq
);
   generate
      if (STYLE == IRQ_COMB) begin : g_comb
         assign irq = |status;
      end else begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |status;
         end
         assign irq = irq_q;
      end
   endgenerate
endmodule

// File: rtl/cos_detector.sv
module cos_detector
   import cosd_pkg::*;
#(
   parameter int         NUM_BANKS = 4,
   parameter int         BANK_W    = 8,
   parameter irq_style_e IRQ_STYLE = IRQ_COMB,
   localparam int        STAT_W    = NUM_BANKS * BANK_W,
   localparam int        EN_W      = 2 * NUM_BANKS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] sync_in,
   input  logic [EN_W-1:0]   edge_en,
   input  logic [NUM_BANKS-1:0] clr_lane,
   input  logic [STAT_W-1:0] clr_data,
   output logic [STAT_W-1:0] cos_status,
   output logic              irq
);
   generate
      if (NUM_BANKS < 1 || BANK_W < 1) begin : g_bad_cfg
         $error("cos_detector: NUM_BANKS and BANK_W must be at least 1");
      end
   endgenerate

   logic              primed_q;
   logic [STAT_W-1:0] hit_all;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed_q <= 1'b0;
      else        primed_q <= 1'b1;
   end

   genvar b;
   generate
      for (b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic [BANK_W-1:0] lane_mask;
         assign lane_mask = {BANK_W{clr_lane[b]}} & clr_data[b*BANK_W +: BANK_W];

         cosd_bank #(.W(BANK_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .primed   (primed_q),
            .rise_en  (edge_en[b]),
            .fall_en  (edge_en[b+NUM_BANKS]),
            .din      (sync_in[b*BANK_W +: BANK_W]),
            .clr_mask (lane_mask),
            .status   (cos_status[b*BANK_W +: BANK_W]),
            .hit_o    (hit_all[b*BANK_W +: BANK_W])
         );
      end
   endgenerate

   cosd_irq_out #(.W(STAT_W), .STYLE(IRQ_STYLE)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .status (cos_status),
      .irq    (irq)
   );

   // R9
   prime_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !primed_q |=> (cos_status == '0));

   generate
      if (IRQ_STYLE == IRQ_COMB) begin : g_irq_chk
         // R8
         irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq) |-> $past(|hit_all));
         // R8
         irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq) |-> $past(|clr_lane));
      end
   endgenerate
endmodule

// File: tb/tb_cos_detector.sv
module tb_cos_detector;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 4;
   localparam int BW = 8;
   localparam int SW = NB * BW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [SW-1:0] sync_in = '0;
   logic [2*NB-1:0] edge_en = '0;
   logic [NB-1:0] clr_lane = '0;
   logic [SW-1:0] clr_data = '0;
   logic [SW-1:0] cos_status;
   logic          irq;

   int n_checks = 0;
   int n_fail   = 0;

   logic [SW-1:0] m_prev   = '0;
   logic          m_primed = 1'b0;
   logic [SW-1:0] m_stat   = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cos_detector dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_in    (sync_in),
      .edge_en    (edge_en),
      .clr_lane   (clr_lane),
      .clr_data   (clr_data),
      .cos_status (cos_status),
      .irq        (irq)
   );

   function automatic logic [SW-1:0] model_next(
      input logic [SW-1:0] stat, input logic [SW-1:0] prev, input logic primed,
      input logic [SW-1:0] d, input logic [2*NB-1:0] en,
      input logic [NB-1:0] lane, input logic [SW-1:0] cdata);
      logic [SW-1:0] hit;
      logic [SW-1:0] clr;
      hit = '0;
      clr = '0;
      for (int k = 0; k < SW; k++) begin
         int bank;
         bank = k / BW;
         if (primed) begin
            if (en[bank] && d[k] && !prev[k]) hit[k] = 1'b1;
            if (en[bank+NB] && !d[k] && prev[k]) hit[k] = 1'b1;
         end
         if (lane[bank] && cdata[k]) clr[k] = 1'b1;
      end
      return (stat & ~clr) | hit;
   endfunction

   task automatic check32(input string tag, input logic [SW-1:0] act, input logic [SW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check1(input string tag, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   // drive at the falling edge, sample at the next falling edge
   task automatic step(input logic [SW-1:0] d, input logic [2*NB-1:0] e,
                       input logic [NB-1:0] l, input logic [SW-1:0] c, input string tag);
      logic [SW-1:0] exp;
      sync_in  = d;
      edge_en  = e;
      clr_lane = l;
      clr_data = c;
      exp = model_next(m_stat, m_prev, m_primed, d, e, l, c);
      m_prev   = d;
      m_primed = 1'b1;
      m_stat   = exp;
      @(posedge clk);
      @(negedge clk);
      check32({tag, " status"}, cos_status, exp);
      check1({tag, " irq (R8)"}, irq, exp != '0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      // R1: reset state, inputs busy and all enables on
      sync_in = 32'hFFFF_0000;
      edge_en = 8'hFF;
      repeat (3) @(negedge clk);
      check32("R1 status in reset", cos_status, '0);
      check1("R1 irq in reset", irq, 1'b0);
      rst_n = 1'b1;
      // R9: first cycle loads the reference, no edge although prev was zero
      step(32'hFFFF_0000, 8'hFF, 4'h0, '0, "R9 first cycle");
      check32("R9 no false edge", cos_status, '0);
      step(32'hFFFF_0000, 8'h00, 4'h0, '0, "R9 settle");

      // R2 and R4: rising enabled for bank 0 only; bit 3 and bit 9 rise
      step(32'hFFFF_0208, 8'h01, 4'h0, '0, "R2 rising bank0");
      check32("R2/R4 only bank0 bit", cos_status, 32'h0000_0008);
      check1("R8 irq high", irq, 1'b1);

      // R3: falling enabled for bank 2 (enable bit 6); bit 16 falls, bit 24 falls with no enable
      step(32'hFEFE_0208, 8'h40, 4'h0, '0, "R3 falling bank2");
      check32("R3 bank2 fall", cos_status, 32'h0001_0008);

      // R4: falling edge in bank 0 while only rising is enabled there
      step(32'hFEFE_0200, 8'h01, 4'h0, '0, "R4 wrong direction");
      check32("R4 ignored", cos_status, 32'h0001_0008);

      // R5: hold
      step(32'hFEFE_0200, 8'h01, 4'h0, '0, "R5 hold a");
      step(32'hFEFE_0200, 8'h01, 4'h0, '0, "R5 hold b");
      check32("R5 sticky", cos_status, 32'h0001_0008);

      // R10: enables off, many edges, existing bits kept
      step(32'h0101_FFFF, 8'h00, 4'h0, '0, "R10 disabled");
      check32("R10 kept, no new", cos_status, 32'h0001_0008);

      // R6: lane 0 strobe with all-ones data; bank 2 data bit set but lane 2 off
      step(32'h0101_FFFF, 8'h00, 4'h1, 32'hFFFF_FFFF, "R6 lane0 clear");
      check32("R6 partial lane", cos_status, 32'h0001_0000);
      // R6: lane strobe on but data bit zero
      step(32'h0101_FFFF, 8'h00, 4'h4, 32'h0000_0000, "R6 zero data");
      check32("R6 zero data keeps", cos_status, 32'h0001_0000);

      // R7: bit 20 rises (bank2 rising, enable bit 2) while lane 2 clears bits 16 and 20
      step(32'h0111_FFFF, 8'h04, 4'h4, 32'h0011_0000, "R7 set vs clear");
      check32("R7 set wins", cos_status, 32'h0010_0000);

      // R6 and R8: clear all lanes
      step(32'h0111_FFFF, 8'h00, 4'hF, 32'hFFFF_FFFF, "R6 full clear");
      check32("R6 all cleared", cos_status, '0);
      check1("R8 irq low", irq, 1'b0);

      // bank 3 both directions (R2/R3 on the top bank)
      step(32'hF011_FFFF, 8'h88, 4'h0, '0, "R2 R3 bank3");
      check32("R2 R3 bank3 edges", cos_status, 32'hF100_0000);
      step(32'hF011_FFFF, 8'h00, 4'hF, 32'hFFFF_FFFF, "R6 clear again");

      // random mix: inputs, enables and clears, checked against the model
      for (int i = 0; i < 400; i++) begin
         logic [SW-1:0] d;
         logic [NB-1:0] l;
         d = ($urandom % 2 == 0) ? sync_in ^ (32'h1 << ($urandom % SW)) : $urandom;
         l = ($urandom % 3 == 0) ? 4'($urandom) : 4'h0;
         step(d, 8'($urandom), l, $urandom, "R2 R3 R5 R6 R7 random");
      end

      // R1 again: reset in mid-run drops status
      rst_n = 1'b0;
      m_stat = '0;
      m_primed = 1'b0;
      @(negedge clk);
      check32("R1 status after re-reset", cos_status, '0);
      check1("R1 irq after re-reset", irq, 1'b0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule